// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Ready Handshake

This block receives bytes over a clocked serial link, least significant bit first. It runs in one of two roles. As a slave it takes the bit clock from the far end and drives an active-low ready line, which tells the sender whether it may start the next byte. As a master it makes the bit clock from the system clock through a programmable divider, and it starts a byte only when the far end's active-low ready line is low.

Finished bytes go into a four-entry FIFO. The FIFO has a pop port, a registered read-data output, an occupancy count, a full flag and a sticky overrun flag. If a byte finishes while the FIFO is full, that byte is dropped and reception is frozen until the next pop. With mask mode on, a full FIFO holds the handshake off before any data can be lost. In slave mode the ready line stays high. In master mode no clock pulses are sent.

Top module: `sync_serial_rx`

## Requirements
- R1: While `rx_en_i` is low, `rdy_no` is high. In slave mode (`master_i`=0), raising `rx_en_i` drives `rdy_no` low when the FIFO is empty and nothing blocks reception.
- R2: In slave mode, `rdy_no` goes high once bit 0 of a byte has been sampled. It goes low again once bit 7 has been sampled, as long as the FIFO is not blocked.
- R3: Bits are sampled on the rising edge of the serial clock. The first bit sampled is bit 0 of the byte and the eighth is bit 7. Bytes leave the FIFO in the order they arrived.
- R4: The stored byte count is the value {`full_o`,`count_o`}. So four stored bytes read as `full_o`=1 with `count_o`=0, and one stored byte reads as `count_o`=1.
- R5: If a byte finishes while the FIFO holds four bytes and there is no pop in the same cycle, the byte is discarded. `overrun_o` is set and `rdy_no` is forced high. Serial clock edges are ignored until a pop, after which `rdy_no` returns low and the next byte is received intact.
- R6: With `mask_en_i`=0 in slave mode, `rdy_no` is low even when the FIFO is full.
- R7: With `mask_en_i`=1 in slave mode, `rdy_no` is high whenever the FIFO is full, and goes low again after a pop.
- R8: In master mode, no `sclk_o` pulse starts while the synchronized `rdy_ni` is high. With `mask_en_i`=1, no `sclk_o` pulse starts while the FIFO is full.
- R9: In master mode, `sclk_o` idles low, and each high and low phase lasts `div_i`+1 system clocks. `sclk_o` is low whenever `master_i` or `rx_en_i` is low.
- R10: Dropping `rx_en_i` empties the FIFO on the next clock, and the discarded bytes never appear on `rdata_o`.
- R11: `overrun_o` stays set until `ovr_clr_i` is pulsed. Clearing reception does not clear it.
- R12: A pop on an empty FIFO leaves `rdata_o` and the count unchanged.
- R13: `rdata_o` shows the oldest stored byte on the clock edge that follows a clock edge with `pop_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Reception enable; low flushes the FIFO |
| master_i | input | 1 | 1 = make the bit clock, 0 = take it from outside |
| mask_en_i | input | 1 | Holds off the handshake while the FIFO is full |
| div_i | input | DIV_W | Half-period of `sclk_o` minus one, in system clocks |
| sclk_i | input | 1 | Serial clock from the far end (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sin_i | input | 1 | Serial data in |
| rdy_ni | input | 1 | Active-low ready from the far end (master mode) |
| rdy_no | output | 1 | Active-low ready to the far end (slave mode) |
| pop_i | input | 1 | Removes the oldest byte from the FIFO |
| rdata_o | output | DATA_W | Last popped byte |
| count_o | output | 2 | Stored byte count, modulo 4 |
| full_o | output | 1 | FIFO holds four bytes |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench drives slave bytes bit by bit and checks the ready line right after bit 0 and right after bit 7. A design that moves these points, or leaves ready low during a byte, fails at once. It then overruns the FIFO and sends a whole byte while reception is frozen, followed by a fresh byte after the pop. A design that keeps shifting while frozen delivers that fresh byte corrupted. In master mode the bench counts clock pulses while ready is held off and while a masked FIFO is full, and it times the high phase. A wrong divider, or a clock that ignores the mask, gives the wrong count. Flushing, the sticky flag and a pop on an empty FIFO are checked against values left from earlier traffic.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ssrx_clkgen.sv
module ssrx_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             byte_end_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             sample_o,
  output logic             busy_o
);
  logic [DIV_W-1:0] dcnt_q;
  logic             sclk_q, busy_q, tick;

  assign tick = busy_q && (dcnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (abort_i) begin
      dcnt_q <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      dcnt_q <= '0;
      busy_q <= start_i;
    end else if (tick) begin
      dcnt_q <= '0;
      sclk_q <= ~sclk_q;
      // falling edge after the last bit ends the byte
      if (sclk_q && byte_end_i) busy_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign sample_o = tick && !sclk_q;
  assign sclk_o   = sclk_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              mid_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, sh_nxt;

  assign sh_nxt = {bit_i, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (sample_i) begin
      sh_q  <= sh_nxt;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign byte_vld_o = sample_i && (cnt_q == LAST);
  assign byte_o     = sh_nxt;
  assign mid_o      = (cnt_q != '0);
endmodule

// File: rtl/ssrx_fifo.sv
module ssrx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     push_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     pop_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [$clog2(DEPTH)-1:0] count_o,
  output logic                     full_o,
  output logic                     room_o,
  output logic                     popped_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned OCC_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [OCC_W-1:0]  occ_q;
  logic [DATA_W-1:0] rdata_q;
  logic              do_pop, do_push;

  assign do_pop  = pop_i && (occ_q != '0) && !flush_i;
  assign room_o  = (occ_q != OCC_MAX) || do_pop;
  assign do_push = push_i && room_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      occ_q   <= '0;
      rdata_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      if (do_pop) begin
        rd_q    <= (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
        rdata_q <= mem_q[rd_q];
      end
      case ({do_push, do_pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign rdata_o  = rdata_q;
  assign count_o  = occ_q[PTR_W-1:0];
  assign full_o   = (occ_q == OCC_MAX);
  assign popped_o = do_pop;
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import ssrx_pkg::*;
#(
  parameter int unsigned DATA_W      = BYTE_W,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_en_i,
  input  logic                     master_i,
  input  logic                     mask_en_i,
  input  logic [DIV_W-1:0]         div_i,
  input  logic                     sclk_i,
  output logic                     sclk_o,
  input  logic                     sin_i,
  input  logic                     rdy_ni,
  output logic                     rdy_no,
  input  logic                     pop_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [$clog2(DEPTH)-1:0] count_o,
  output logic                     full_o,
  input  logic                     ovr_clr_i,
  output logic                     overrun_o
);
  logic [2:0] sync_q;
  logic sclk_s, sin_s, rdy_s, sclk_d_q, slave_rise;
  logic frozen_q, ovr_q;
  logic master_run, start, gen_sample, gen_busy;
  logic sample, bit_in, byte_vld, mid, room, popped, overrun_evt, full;
  logic [DATA_W-1:0] byte_w;

  ssrx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({rdy_ni, sin_i, sclk_i}), .q_o(sync_q)
  );
  assign {rdy_s, sin_s, sclk_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end
  assign slave_rise = sclk_s && !sclk_d_q;

  assign master_run = rx_en_i && master_i;
  assign start = master_run && !frozen_q && !rdy_s && !(mask_en_i && full);

  ssrx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .abort_i(!master_run), .start_i(start), .byte_end_i(!mid),
    .div_i(div_i), .sclk_o(sclk_o), .sample_o(gen_sample), .busy_o(gen_busy)
  );

  assign sample = master_i ? gen_sample : (slave_rise && rx_en_i && !frozen_q);
  assign bit_in = master_i ? sin_i : sin_s;

  ssrx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!rx_en_i),
    .sample_i(sample), .bit_i(bit_in),
    .byte_vld_o(byte_vld), .byte_o(byte_w), .mid_o(mid)
  );

  ssrx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(!rx_en_i),
    .push_i(byte_vld), .wdata_i(byte_w), .pop_i(pop_i),
    .rdata_o(rdata_o), .count_o(count_o), .full_o(full),
    .room_o(room), .popped_o(popped)
  );

  assign overrun_evt = byte_vld && !room && rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (!rx_en_i)         frozen_q <= 1'b0;
      else if (overrun_evt) frozen_q <= 1'b1;
      else if (popped)      frozen_q <= 1'b0;
      if (overrun_evt)      ovr_q <= 1'b1;
      else if (ovr_clr_i)   ovr_q <= 1'b0;
    end
  end

  // gen_busy is only needed inside the generator; the handshake uses mid
  logic unused_busy;
  assign unused_busy = gen_busy;

  assign rdy_no    = master_i || !(rx_en_i && !mid && !frozen_q && !(mask_en_i && full));
  assign full_o    = full;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              master_i,
  input logic              mask_en_i,
  input logic              pop_i,
  input logic              ovr_clr_i,
  input logic              rdy_no,
  input logic              sclk_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              full_o,
  input logic              overrun_o,
  input logic [DATA_W-1:0] rdata_o
);
  a_r1_disabled_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> rdy_no);

  a_r4_full_count_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (count_o == '0));

  a_r5_overrun_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(full_o));

  a_r7_mask_holds_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && mask_en_i && full_o && rx_en_i) |-> rdy_no);

  a_r9_sclk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i || !rx_en_i) |=> !sclk_o);

  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (count_o == '0 && !full_o));

  a_r11_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  a_r12_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_o == '0 && !full_o) |=> $stable(rdata_o));
endmodule

bind sync_serial_rx ssrx_checker u_chk (.*);

// File: tb/sim_sync_serial_rx.sv
`timescale 1ns/1ps
module sim_sync_serial_rx;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_en_i = 0, master_i = 0, mask_en_i = 0, sclk_i = 0, sin_s = 0, sin_m = 0;
  logic rdy_ni = 1, pop_i = 0, ovr_clr_i = 0;
  logic [7:0] div_i = 8'd3;
  logic sclk_o, rdy_no, full_o, overrun_o, sin_i;
  logic [7:0] rdata_o;
  logic [1:0] count_o;

  int checks = 0, failures = 0, sclk_rises = 0, mdl_idx = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mdl_q[$];
  logic [7:0] mdl_cur = 8'h00;

  always #4 clk_i = ~clk_i;
  assign sin_i = master_i ? sin_m : sin_s;

  sync_serial_rx u0 (.*);

  always @(posedge sclk_o) sclk_rises++;

  // far-end data source for master mode
  always @(posedge sclk_o) begin
    #1;
    mdl_idx = mdl_idx + 1;
    if (mdl_idx == 8) begin
      mdl_idx = 0;
      mdl_cur = (mdl_q.size() > 0) ? mdl_q.pop_front() : 8'h00;
    end
    sin_m = mdl_cur[mdl_idx[2:0]];
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slave_bit(input logic b);
    sin_s = b; sclk_i = 0; wclk(4);
    sclk_i = 1; wclk(5);
  endtask

  task automatic slave_byte(input logic [7:0] d, input bit keep, input bit chk_rdy);
    for (int i = 0; i < 8; i++) begin
      slave_bit(d[i]);
      if (chk_rdy && i == 0) chk(rdy_no == 1'b1, "R2 ready high after bit0", rdy_no, 1);
      if (chk_rdy && i == 7) chk(rdy_no == 1'b0, "R2 ready low after bit7", rdy_no, 0);
    end
    if (keep) exp_q.push_back(d);
  endtask

  // monitor: pop one byte and compare with the scoreboard head
  task automatic monitor_pop(input string req);
    logic [7:0] e;
    pop_i = 1; wclk(1); pop_i = 0;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(rdata_o == e, req, rdata_o, e);
    end
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) monitor_pop(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0, n;
    wclk(3); rst_ni = 1; wclk(2);
    chk(rdy_no == 1, "R1 reset ready high", rdy_no, 1);
    chk(count_o == 0 && !full_o, "R4 reset empty", {full_o, count_o}, 0);
    chk(overrun_o == 0, "R11 reset overrun clear", overrun_o, 0);

    rx_en_i = 1; wclk(2);
    chk(rdy_no == 0, "R1 enable drives ready low", rdy_no, 0);
    slave_byte(8'hA5, 1, 1);
    chk(count_o == 1 && !full_o, "R4 one byte stored", {full_o, count_o}, 1);
    monitor_pop("R3 R13 first byte");
    pop_i = 1; wclk(1); pop_i = 0; wclk(1);
    chk(rdata_o == 8'hA5, "R12 empty pop keeps data", rdata_o, 8'hA5);
    chk(count_o == 0 && !full_o, "R12 empty pop keeps count", {full_o, count_o}, 0);

    // fill with mask off
    slave_byte(8'h3C, 1, 1); slave_byte(8'h81, 1, 1);
    slave_byte(8'hFF, 1, 1); slave_byte(8'h00, 1, 1);
    chk(full_o && count_o == 0, "R4 four bytes full", {full_o, count_o}, 4);
    chk(rdy_no == 0, "R6 ready low while full", rdy_no, 0);

    // overrun and freeze
    slave_byte(8'h5A, 0, 0);
    chk(overrun_o == 1, "R5 overrun flagged", overrun_o, 1);
    chk(rdy_no == 1, "R5 ready forced high", rdy_no, 1);
    slave_byte(8'hC3, 0, 0);
    chk(rdy_no == 1, "R5 still frozen", rdy_no, 1);
    monitor_pop("R5 oldest byte kept");
    chk(rdy_no == 0, "R5 ready back after pop", rdy_no, 0);
    slave_byte(8'h77, 1, 1);
    drain("R5 R3 order after overrun");
    chk(overrun_o == 1, "R11 overrun sticky", overrun_o, 1);
    ovr_clr_i = 1; wclk(1); ovr_clr_i = 0; wclk(1);
    chk(overrun_o == 0, "R11 cleared by pulse", overrun_o, 0);

    // mask mode, slave
    mask_en_i = 1;
    slave_byte(8'h12, 1, 1); slave_byte(8'h34, 1, 1);
    slave_byte(8'h56, 1, 1); slave_byte(8'h78, 1, 0);
    chk(rdy_no == 1, "R7 ready held high when full", rdy_no, 1);
    monitor_pop("R7 R3 masked data");
    chk(rdy_no == 0, "R7 ready low after pop", rdy_no, 0);

    // flush
    rx_en_i = 0; wclk(2);
    chk(count_o == 0 && !full_o, "R10 flush empties", {full_o, count_o}, 0);
    exp_q.delete();
    rx_en_i = 1; wclk(2);
    slave_byte(8'h9E, 1, 1);
    monitor_pop("R10 only new byte after flush");
    chk(count_o == 0 && !full_o, "R10 count after flush and pop", {full_o, count_o}, 0);

    // master mode with mask
    rx_en_i = 0; master_i = 1; mask_en_i = 1; div_i = 8'd3; rdy_ni = 1; wclk(2);
    mdl_q = '{8'h11, 8'hE7, 8'h4C, 8'hB2, 8'h96};
    exp_q = '{8'h11, 8'hE7, 8'h4C, 8'hB2, 8'h96};
    mdl_cur = mdl_q.pop_front(); mdl_idx = 0; sin_m = mdl_cur[0];
    rx_en_i = 1; sclk_rises = 0; wclk(40);
    chk(sclk_rises == 0, "R8 no clock while far end not ready", sclk_rises, 0);
    rdy_ni = 0;
    @(posedge sclk_o);
    n = 0; @(negedge clk_i);
    while (sclk_o) begin n++; @(negedge clk_i); end
    chk(n == 4, "R9 high phase length", n, 4);
    wclk(400);
    chk(full_o && count_o == 0, "R8 master filled FIFO", {full_o, count_o}, 4);
    r0 = sclk_rises; wclk(200);
    chk(sclk_rises == r0, "R8 clock stopped while full", sclk_rises, r0);
    chk(overrun_o == 0, "R8 no overrun in masked master", overrun_o, 0);
    monitor_pop("R3 master first byte");
    wclk(150);
    chk(full_o, "R8 master resumed after pop", full_o, 1);
    rdy_ni = 1; wclk(5);
    drain("R3 master byte order");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule